// File: doc/BRIEF.md
# Machine Cycle Timing Sequencer

This block divides the oscillator clock into machine cycles. Each machine cycle has twelve oscillator periods, grouped as six states of two phases each. For every slot the block reports the current state number and phase. It drives the external address latch enable and produces the strobes that load an opcode or an operand byte. It also issues program-counter advance pulses, flags the final slot of each instruction and generates the read and write strobes for external data moves.

A decoder supplies three facts about the instruction now starting: whether it has two bytes, how many machine cycles it takes, and whether it is an external data move (with its direction). The sequencer samples these facts at the opcode-latch slot and holds them until the instruction completes. The decoder inputs therefore only need to be valid for that single slot.

Top module: `mcycle_seq`

Slots are counted 0 to 11. Slot 2·(state−1)+(phase−1) corresponds to state 1..6 and phase 1..2.

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer returns to state 1 phase 1 (`state_num`=1, `phase_two`=0) and enters a fresh instruction. In that slot every strobe output is low.
- R2: Each clock advances one slot. `phase_two` alternates 0,1. `state_num` increments after phase 2 and wraps from 6 back to 1, so a machine cycle is 12 clocks.
- R3: `ale` is high in exactly four slots of every machine cycle: state 1 phase 2, state 2 phase 1, state 4 phase 2 and state 5 phase 1. The only exception is the second cycle of an external data move (see R7).
- R4: `op_latch` and `pc_inc` are high at state 1 phase 2 of the first cycle of every instruction, and `op_latch` is high at no other slot.
- R5: In a two-byte instruction, `opnd_latch` and `pc_inc` are high at state 4 phase 2 of the first cycle. In a one-byte instruction the state-4 fetch still happens (`ale` still pulses), but `opnd_latch` and `pc_inc` stay low there.
- R6: `instr_done` is high only at state 6 phase 2 of an instruction's last cycle. `dec_cycles` encodes the cycle count as 00 for one cycle, 01 for two cycles, and 10 or 11 for four cycles.
- R7: When `dec_xdata` is 1, the instruction takes two cycles and one byte, whatever `dec_cycles` and `dec_two_byte` say. In its second cycle `ale` stays low. A strobe is high from state 1 phase 2 through state 5 phase 1: `xwr` when `dec_xwrite`=1, otherwise `xrd`.
- R8: The decoder inputs are sampled only at the opcode-latch slot. Changing them later in the instruction has no effect on any output until `instr_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per period |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_two_byte | input | 1 | Instruction has a second byte |
| dec_cycles | input | 2 | Cycle count code (00=1, 01=2, 1x=4) |
| dec_xdata | input | 1 | Instruction is an external data move |
| dec_xwrite | input | 1 | External data move writes (else reads) |
| state_num | output | 3 | Current state, 1 to 6 |
| phase_two | output | 1 | 0 in phase 1, 1 in phase 2 |
| ale | output | 1 | External address latch enable |
| op_latch | output | 1 | Load opcode into instruction register |
| opnd_latch | output | 1 | Capture second instruction byte |
| pc_inc | output | 1 | Advance program counter |
| instr_done | output | 1 | Instruction completes in this slot |
| xrd | output | 1 | External data read strobe |
| xwr | output | 1 | External data write strobe |

## Verification
The hardest condition to reach is a change of the decoder inputs in the middle of an instruction. The outputs must keep following the values captured at the opcode slot, not the live pins. To cover it, the stimulus drives the true instruction facts only up to the opcode-latch edge and then drives their bitwise complement for the rest of the instruction, across all 32 input combinations. A reset raised inside the second cycle of a four-cycle instruction confirms that the cycle counter restarts as well as the slot counter.

// File: rtl/mcs_pkg.sv
// Package for the machine cycle sequencer. Holds the slot geometry and the
// named slot positions the strobe decode relies on.
// Assumes two phases per state; slot index = (state-1)*PHASES + (phase-1).
package mcs_pkg;
    localparam int NUM_STATES = 6;
    localparam int PHASES     = 2;
    localparam int NUM_SLOTS  = NUM_STATES * PHASES;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int STATE_W    = $clog2(NUM_STATES + 1);
    localparam int CYC_W      = 2;
    localparam int NUM_ALE    = 4;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [CYC_W-1:0]  cyc_t;

    typedef enum logic [1:0] {
        CYC_ONE   = 2'b00,
        CYC_TWO   = 2'b01,
        CYC_FOUR  = 2'b10,
        CYC_FOURX = 2'b11
    } cyc_code_e;

    // Map a 1-based state and phase onto a slot index.
    function automatic slot_t slot_of(input int st, input int ph);
        return slot_t'((st - 1) * PHASES + (ph - 1));
    endfunction

    localparam slot_t OPC_SLOT  = slot_of(1, 2);
    localparam slot_t OPND_SLOT = slot_of(4, 2);
    localparam slot_t LAST_SLOT = slot_of(NUM_STATES, PHASES);
    localparam slot_t XS_FIRST  = slot_of(1, 2);
    localparam slot_t XS_LAST   = slot_of(5, 1);
    localparam slot_t ALE_SLOTS [NUM_ALE] =
        '{slot_of(1, 2), slot_of(2, 1), slot_of(4, 2), slot_of(5, 1)};
endpackage

// File: rtl/mcs_slot_ctr.sv
// Slot counter: walks the twelve oscillator slots of a machine cycle and
// reports state number and phase. Assumes PHASES divides the slot count.
module mcs_slot_ctr
    import mcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output slot_t              slot,
    output logic [STATE_W-1:0] state_num,
    output logic               phase_two
);
    // Advance one slot per clock, wrapping after the last phase of state 6.
    always_ff @(posedge clk) begin
        if (!rst_n)                 slot <= '0;
        else if (slot == LAST_SLOT) slot <= '0;
        else                        slot <= slot + slot_t'(1);
    end

    // Derive 1-based state number and phase flag from the slot index.
    always_comb begin
        state_num = STATE_W'(slot / slot_t'(PHASES)) + STATE_W'(1);
        phase_two = (slot % slot_t'(PHASES)) == slot_t'(PHASES - 1);
    end
endmodule

// File: rtl/mcs_instr_track.sv
// Instruction tracker: captures the decoder facts at the opcode slot of a
// first cycle and counts machine cycles until the last one completes.
// Assumes the decoder inputs are valid during the opcode slot.
module mcs_instr_track
    import mcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slot_t      slot,
    input  logic       dec_two_byte,
    input  logic [1:0] dec_cycles,
    input  logic       dec_xdata,
    input  logic       dec_xwrite,
    output cyc_t       cyc,
    output logic       first_cycle,
    output logic       last_cycle,
    output logic       two_byte_q,
    output logic       xdata_q,
    output logic       xwrite_q
);
    cyc_t last_idx_q;
    cyc_t last_idx_d;
    logic capture;

    // Translate the cycle code (or the external-move override) to a last index.
    always_comb begin
        if (dec_xdata) begin
            last_idx_d = cyc_t'(1);
        end else begin
            case (cyc_code_e'(dec_cycles))
                CYC_ONE: last_idx_d = cyc_t'(0);
                CYC_TWO: last_idx_d = cyc_t'(1);
                default: last_idx_d = cyc_t'(3);
            endcase
        end
        capture = (slot == OPC_SLOT) && (cyc == '0);
    end

    // Hold the decoder facts from the opcode slot until the next instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_idx_q <= '0;
            two_byte_q <= 1'b0;
            xdata_q    <= 1'b0;
            xwrite_q   <= 1'b0;
        end else if (capture) begin
            last_idx_q <= last_idx_d;
            two_byte_q <= dec_two_byte && !dec_xdata;
            xdata_q    <= dec_xdata;
            xwrite_q   <= dec_xdata && dec_xwrite;
        end
    end

    // Step the cycle counter at each cycle boundary, clearing after the last.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cyc <= '0;
        else if (slot == LAST_SLOT) begin
            if (cyc == last_idx_q)     cyc <= '0;
            else                       cyc <= cyc + cyc_t'(1);
        end
    end

    // Flag first and last cycles of the current instruction.
    always_comb begin
        first_cycle = (cyc == '0);
        last_cycle  = (cyc == last_idx_q);
    end
endmodule

// File: rtl/mcs_strobes.sv
// Strobe decode: turns slot position and captured instruction facts into
// the latch, program-counter, completion and external-data strobes.
// Assumes the captured facts are stable from the slot after the opcode slot.
module mcs_strobes
    import mcs_pkg::*;
(
    input  slot_t slot,
    input  cyc_t  cyc,
    input  logic  first_cycle,
    input  logic  last_cycle,
    input  logic  two_byte_q,
    input  logic  xdata_q,
    input  logic  xwrite_q,
    output logic  ale,
    output logic  op_latch,
    output logic  opnd_latch,
    output logic  pc_inc,
    output logic  instr_done,
    output logic  xrd,
    output logic  xwr
);
    logic ale_hit;
    logic xd_cycle;
    logic xwin;

    // Find whether the slot is one of the address-latch slots.
    always_comb begin
        ale_hit = 1'b0;
        for (int i = 0; i < NUM_ALE; i++) begin
            if (slot == ALE_SLOTS[i]) ale_hit = 1'b1;
        end
    end

    // Decode every strobe for the current slot.
    always_comb begin
        xd_cycle   = xdata_q && (cyc == cyc_t'(1));
        ale        = ale_hit && !xd_cycle;
        op_latch   = (slot == OPC_SLOT) && first_cycle;
        opnd_latch = (slot == OPND_SLOT) && first_cycle && two_byte_q;
        pc_inc     = op_latch || opnd_latch;
        instr_done = (slot == LAST_SLOT) && last_cycle;
        xwin       = xd_cycle && (slot >= XS_FIRST) && (slot <= XS_LAST);
        xrd        = xwin && !xwrite_q;
        xwr        = xwin && xwrite_q;
    end
endmodule

// File: rtl/mcycle_seq.sv
// Machine cycle timing sequencer top. Connects the slot counter, the
// instruction tracker and the strobe decode. Outputs are decoded from
// registered state, so they settle shortly after each rising clock edge.
module mcycle_seq
    import mcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec_two_byte,
    input  logic [1:0] dec_cycles,
    input  logic       dec_xdata,
    input  logic       dec_xwrite,
    output logic [2:0] state_num,
    output logic       phase_two,
    output logic       ale,
    output logic       op_latch,
    output logic       opnd_latch,
    output logic       pc_inc,
    output logic       instr_done,
    output logic       xrd,
    output logic       xwr
);
    slot_t slot;
    cyc_t  cyc;
    logic  first_cycle, last_cycle, two_byte_q, xdata_q, xwrite_q;

    mcs_slot_ctr u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .state_num (state_num),
        .phase_two (phase_two)
    );

    mcs_instr_track u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot         (slot),
        .dec_two_byte (dec_two_byte),
        .dec_cycles   (dec_cycles),
        .dec_xdata    (dec_xdata),
        .dec_xwrite   (dec_xwrite),
        .cyc          (cyc),
        .first_cycle  (first_cycle),
        .last_cycle   (last_cycle),
        .two_byte_q   (two_byte_q),
        .xdata_q      (xdata_q),
        .xwrite_q     (xwrite_q)
    );

    mcs_strobes u_strb (
        .slot        (slot),
        .cyc         (cyc),
        .first_cycle (first_cycle),
        .last_cycle  (last_cycle),
        .two_byte_q  (two_byte_q),
        .xdata_q     (xdata_q),
        .xwrite_q    (xwrite_q),
        .ale         (ale),
        .op_latch    (op_latch),
        .opnd_latch  (opnd_latch),
        .pc_inc      (pc_inc),
        .instr_done  (instr_done),
        .xrd         (xrd),
        .xwr         (xwr)
    );
endmodule

// File: rtl/mcycle_seq_checker.sv
// Property checker for the sequencer, attached through bind. Relates the
// slot outputs to the strobes over time.
module mcycle_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] state_num,
    input logic       phase_two,
    input logic       ale,
    input logic       op_latch,
    input logic       opnd_latch,
    input logic       pc_inc,
    input logic       instr_done,
    input logic       xrd,
    input logic       xwr
);
    // Phase 1 is followed by phase 2 of the same state.
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_two |=> (phase_two && $stable(state_num)));

    // The last slot of state 6 wraps to state 1 phase 1.
    assert_state_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_two && state_num == 3'd6) |=> (state_num == 3'd1 && !phase_two));

    // Address latch enable only in its four slots.
    assert_ale_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ((state_num == 3'd1 && phase_two) || (state_num == 3'd2 && !phase_two) ||
                 (state_num == 3'd4 && phase_two) || (state_num == 3'd5 && !phase_two)));

    // Opcode strobe sits at state 1 phase 2 and advances the counter.
    assert_opcode_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_latch |-> (state_num == 3'd1 && phase_two && pc_inc));

    // A state-4 counter advance needs a real operand capture.
    assert_dummy_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && state_num == 3'd4) |-> opnd_latch);

    // Completion only at state 6 phase 2.
    assert_done_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> (state_num == 3'd6 && phase_two));

    // External strobes are exclusive and never overlap address latching.
    assert_xfer_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xrd || xwr) |-> (!ale && !(xrd && xwr)));
endmodule

bind mcycle_seq mcycle_seq_checker u_chk (.*);

// File: tb/mcycle_seq_test.sv
// Sweeps every decoder input combination back to back, scrambling the
// decoder inputs after the opcode slot, and checks each output every slot.
module mcycle_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_two_byte = 1'b0;
    logic [1:0] dec_cycles = 2'b00;
    logic       dec_xdata = 1'b0;
    logic       dec_xwrite = 1'b0;
    logic [2:0] state_num;
    logic       phase_two, ale, op_latch, opnd_latch, pc_inc, instr_done, xrd, xwr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    mcycle_seq uut (.*);

    always #10 clk = ~clk;

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reset slot: state 1 phase 1 and all strobes low.
    task automatic chk_reset_slot();
        chk(int'(state_num), 1, "R1 state");
        chk(int'(phase_two), 0, "R1 phase");
        chk(int'({ale, op_latch, opnd_latch, pc_inc, instr_done, xrd, xwr}), 0, "R1 strobes");
    endtask

    // Run one instruction; entered and left at a negedge of a slot-0 period.
    // abort_at >= 0 applies reset at that flat slot index instead of finishing.
    task automatic run_instr(input bit two, input bit [1:0] cy, input bit xd,
                             input bit xw, input int abort_at);
        int ncyc;
        bit twob;
        ncyc = xd ? 2 : (cy == 2'b00 ? 1 : (cy == 2'b01 ? 2 : 4));
        twob = two && !xd;
        for (int c = 0; c < ncyc; c++) begin
            for (int s = 0; s < 12; s++) begin
                bit xc, xwin, opx, opnx;
                if (abort_at == c * 12 + s) begin
                    rst_n = 1'b0;
                    @(posedge clk); @(negedge clk);
                    chk_reset_slot();
                    rst_n = 1'b1;
                    return;
                end
                xc   = xd && (c == 1);
                xwin = xc && (s >= 1) && (s <= 8);
                opx  = (s == 1) && (c == 0);
                opnx = (s == 7) && (c == 0) && twob;
                chk(int'(state_num), s / 2 + 1, "R2 state");
                chk(int'(phase_two), s % 2, "R2 phase");
                chk(int'(ale), int'((s == 1 || s == 2 || s == 7 || s == 8) && !xc), "R3 R7 ale");
                chk(int'(op_latch), int'(opx), "R4 op_latch");
                chk(int'(opnd_latch), int'(opnx), "R5 opnd_latch");
                chk(int'(pc_inc), int'(opx || opnx), "R4 R5 pc_inc");
                chk(int'(instr_done), int'(s == 11 && c == ncyc - 1), "R6 R8 done");
                chk(int'(xrd), int'(xwin && !xw), "R7 xrd");
                chk(int'(xwr), int'(xwin && xw), "R7 xwr");
                if (c == 0 && s == 0) begin
                    dec_two_byte = two; dec_cycles = cy; dec_xdata = xd; dec_xwrite = xw;
                end else if (c == 0 && s == 2) begin
                    // R8: complement the inputs once they have been captured.
                    dec_two_byte = ~two; dec_cycles = ~cy; dec_xdata = ~xd; dec_xwrite = ~xw;
                end
                @(posedge clk); @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_reset_slot();
        rst_n = 1'b1;
        for (int k = 0; k < 32; k++) begin
            run_instr(k[0], k[2:1], k[3], k[4], -1);
        end
        // R1: reset inside the second cycle of a four-cycle instruction.
        run_instr(1'b1, 2'b10, 1'b0, 1'b0, 17);
        run_instr(1'b0, 2'b00, 1'b0, 1'b0, -1);
        run_instr(1'b1, 2'b01, 1'b1, 1'b1, -1);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule